// File: doc/BRIEF.md
# Sync Strobe Routing Controller

This block decides how two active-low external strobes, a system sync and an accumulator sync, reach the timing state of a numerically controlled oscillator. An 8-bit mode register, written through a small byte-wide register port, sets the routing. The mode can gate the system strobe off. It can let the system strobe stand in for the accumulator strobe. It can replace the system strobe with the terminal count of an on-chip sync counter, and it can turn every internal sync into a full diagnostic re-initialization.

The block holds a frequency register, loaded from byte-wide frequency word registers, and a phase accumulator. The accumulator adds the frequency register every clock unless an initialize pulse arrives. Three pulses leave the block: accumulator initialize, frequency load and diagnostic re-initialize. The internal sync is always driven on a sync-out pin. Logic further downstream, such as a checksum unit or control counters, only consumes these pulses.

Top module: `sync_route_ctrl`

## Requirements
- R1: When mode bit 0 is set, a falling system strobe causes no sync-out pulse, no initialize and no frequency load.
- R2: When mode bit 1 is set and the selected accumulator strobe falls, `acc_init` pulses and the phase accumulator takes the value of the frequency register at the next edge. When bit 1 is clear, the strobe does not touch the accumulator.
- R3: When mode bit 2 is set and bit 0 is clear, the system strobe is the selected accumulator strobe and `acc_sync_n` is ignored. In every other case `acc_sync_n` is the selected strobe.
- R4: Address 0 is the mode register. Addresses 1 to 4 hold the frequency word bytes, least significant byte first. A mode write with bit 3 set loads the frequency register from the word. While bit 3 stays set, each word-byte write also loads it. `freq_load` pulses in the cycle after the write, and `freq_q` changes at the edge that ends that cycle.
- R5: When mode bit 4 is set, a fall of the selected accumulator strobe pulses `freq_load` and loads the frequency register from the word.
- R6: When mode bit 5 is set, every internal sync pulses `diag_sync` and also `acc_init`.
- R7: The sync counter restarts on every internal sync. Its terminal count comes 2^LONG_LOG2 clocks after a restart, or 2^TEST_LOG2 clocks when mode bit 6 is set.
- R8: Mode bit 7 selects the counter terminal count as the internal sync. Otherwise the gated system strobe is the internal sync. `sync_out` always shows the internal sync, and each sync is one clock long.
- R9: Each strobe passes through two synchronizer flops and a falling-edge detector. A strobe first sampled low at edge k gives a one-clock pulse in the cycle after edge k+1. A strobe held low acts only once.
- R10: In a cycle without `acc_init`, the phase accumulator adds the frequency register modulo 2^32. An initialize pulse overrides the addition in its cycle.
- R11: After reset the mode, the word, the frequency register, the phase and all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1..4 word bytes |
| wr_data | input | 8 | Register write data |
| sys_sync_n | input | 1 | External system sync strobe, active low |
| acc_sync_n | input | 1 | External accumulator sync strobe, active low |
| sync_out | output | 1 | Internal sync pulse |
| acc_init | output | 1 | Accumulator initialize pulse |
| freq_load | output | 1 | Frequency register load pulse |
| diag_sync | output | 1 | Diagnostic re-initialize pulse |
| freq_q | output | 32 | Frequency register |
| phase_q | output | 32 | Phase accumulator |

## Verification
The routing is driven with system-only, accumulator-only and long-held strobes under each mode combination. This separates the R3 mux from the R1 gate: with bits 0 and 2 both set, only the accumulator strobe may act. Word writes are issued with bit 3 off and then on, which separates an immediate reload from a later synchronous load. The counter is run free in both period settings, with diagnostic routing on. This checks the period, the restart and the spread of each sync to `acc_init`.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;
  // bit 7 down to bit 0
  typedef struct packed {
    logic tc_as_sync;
    logic short_period;
    logic diag_en;
    logic sync_load_en;
    logic direct_load_en;
    logic acc_use_sys;
    logic acc_sync_en;
    logic sys_disable;
  } mode_t;

  localparam int unsigned MODE_ADDR = 0;
endpackage

// File: rtl/strobe_fall.sv
module strobe_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], strobe_n};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/sync_timer.sv
module sync_timer #(
  parameter int unsigned LONG_LOG2 = 20,
  parameter int unsigned TEST_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_mode,
  input  logic restart,
  output logic tc
);
  localparam logic [LONG_LOG2-1:0] LONG_LAST = '1;
  localparam logic [LONG_LOG2-1:0] TEST_LAST = LONG_LOG2'((1 << TEST_LOG2) - 1);

  logic [LONG_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tc = short_mode ? (cnt == TEST_LAST) : (cnt == LONG_LAST);
endmodule

// File: rtl/nco_core.sv
module nco_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word,
  input  logic         load,
  input  logic         init,
  output logic [W-1:0] freq_q,
  output logic [W-1:0] phase_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      phase_q <= '0;
    end else begin
      if (load) freq_q <= word;
      if (init) phase_q <= freq_q;
      else      phase_q <= phase_q + freq_q;
    end
  end
endmodule

// File: rtl/sync_route_ctrl.sv
module sync_route_ctrl
  import sync_route_pkg::*;
#(
  parameter int unsigned LONG_LOG2 = 20,
  parameter int unsigned TEST_LOG2 = 8,
  parameter int unsigned FREQ_W    = 32,
  localparam int unsigned NB = FREQ_W / 8,
  localparam int unsigned AW = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sys_sync_n,
  input  logic              acc_sync_n,
  output logic              sync_out,
  output logic              acc_init,
  output logic              freq_load,
  output logic              diag_sync,
  output logic [FREQ_W-1:0] freq_q,
  output logic [FREQ_W-1:0] phase_q
);
  mode_t             mode_q;
  logic [FREQ_W-1:0] fword;
  logic              ld_pend;
  logic              sys_fall, acc_fall, sys_gated, acc_ev, tc, int_sync;
  logic              word_wr;

  assign word_wr = wr_en && (wr_addr != AW'(MODE_ADDR)) && (wr_addr <= AW'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      fword   <= '0;
      ld_pend <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(MODE_ADDR)) mode_q <= mode_t'(wr_data);
      for (int i = 0; i < NB; i++)
        if (wr_en && wr_addr == AW'(i + 1)) fword[8*i +: 8] <= wr_data;
      ld_pend <= (wr_en && wr_addr == AW'(MODE_ADDR) && wr_data[3])
               || (word_wr && mode_q.direct_load_en);
    end
  end

  strobe_fall #(.STAGES(2)) u_sys_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(sys_sync_n), .fall(sys_fall));

  strobe_fall #(.STAGES(2)) u_acc_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(acc_sync_n), .fall(acc_fall));

  sync_timer #(.LONG_LOG2(LONG_LOG2), .TEST_LOG2(TEST_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .short_mode(mode_q.short_period),
    .restart(int_sync), .tc(tc));

  always_comb begin
    sys_gated = sys_fall & ~mode_q.sys_disable;
    int_sync  = mode_q.tc_as_sync ? tc : sys_gated;
    acc_ev    = (mode_q.acc_use_sys && !mode_q.sys_disable) ? sys_gated : acc_fall;
    diag_sync = mode_q.diag_en & int_sync;
    acc_init  = (mode_q.acc_sync_en & acc_ev) | diag_sync;
    freq_load = ld_pend | (mode_q.sync_load_en & acc_ev);
  end

  assign sync_out = int_sync;

  nco_core #(.W(FREQ_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .word(fword), .load(freq_load),
    .init(acc_init), .freq_q(freq_q), .phase_q(phase_q));
endmodule

// File: rtl/sync_route_chk.sv
module sync_route_chk #(
  parameter int unsigned FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        mode,
  input logic [FREQ_W-1:0] fword,
  input logic [FREQ_W-1:0] freq_q,
  input logic [FREQ_W-1:0] phase_q,
  input logic              sync_out,
  input logic              acc_init,
  input logic              freq_load,
  input logic              diag_sync
);
  a_r10_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_init |=> phase_q == $past(phase_q) + $past(freq_q));

  a_r2_init_value: assert property (@(posedge clk) disable iff (!rst_n)
    acc_init |=> phase_q == $past(freq_q));

  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |=> freq_q == $past(fword));

  a_r4_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_load |=> $stable(freq_q));

  a_r6_diag_spread: assert property (@(posedge clk) disable iff (!rst_n)
    diag_sync |-> (sync_out && acc_init));

  a_r1_sys_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && !mode[7]) |-> !sync_out);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);
endmodule

bind sync_route_ctrl sync_route_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .fword(fword), .freq_q(freq_q),
  .phase_q(phase_q), .sync_out(sync_out), .acc_init(acc_init),
  .freq_load(freq_load), .diag_sync(diag_sync));

// File: tb/sync_route_ctrl_tb.sv
module sync_route_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_LOG2  = 10;
  localparam int TEST_LOG2  = 8;
  localparam int LONGP      = 1 << LONG_LOG2;
  localparam int TESTP      = 1 << TEST_LOG2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic sys_sync_n = 1, acc_sync_n = 1;
  logic sync_out, acc_init, freq_load, diag_sync;
  logic [31:0] freq_q, phase_q;

  int vectors = 0, miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_route_ctrl #(.LONG_LOG2(LONG_LOG2), .TEST_LOG2(TEST_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_sync_n(sys_sync_n), .acc_sync_n(acc_sync_n), .sync_out(sync_out),
    .acc_init(acc_init), .freq_load(freq_load), .diag_sync(diag_sync),
    .freq_q(freq_q), .phase_q(phase_q));

  // Reference model, stated in terms of the requirements
  bit [2:0] m_sys_hist, m_acc_hist;   // [0] newest sample, [2] one older than [1]
  bit [7:0] m_mode;
  bit [31:0] m_word, m_freq, m_phase;
  bit m_ldp;
  int m_cnt;

  function automatic void m_outputs(output bit so, output bit ai, output bit fl, output bit ds);
    bit sys_ev, acc_ev, tc;
    sys_ev = m_sys_hist[2] && !m_sys_hist[1] && !m_mode[0];           // R9, R1
    acc_ev = m_acc_hist[2] && !m_acc_hist[1];
    tc     = (m_cnt == (m_mode[6] ? TESTP - 1 : LONGP - 1));         // R7
    so     = m_mode[7] ? tc : sys_ev;                                   // R8
    if (m_mode[2] && !m_mode[0]) acc_ev = sys_ev;                       // R3
    ds = m_mode[5] && so;                                               // R6
    ai = (m_mode[1] && acc_ev) || ds;                                   // R2
    fl = m_ldp || (m_mode[4] && acc_ev);                                // R4, R5
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sys_hist = '1; m_acc_hist = '1; m_mode = 0; m_word = 0;
      m_freq = 0; m_phase = 0; m_ldp = 0; m_cnt = 0;
    end else begin
      bit so, ai, fl, ds;
      m_outputs(so, ai, fl, ds);
      m_phase = ai ? m_freq : m_phase + m_freq;                         // R10
      if (fl) m_freq = m_word;
      m_cnt = so ? 0 : (m_cnt + 1) % LONGP;
      m_ldp = wr_en && ((wr_addr == 0 && wr_data[3]) ||
                        (wr_addr >= 1 && wr_addr <= 4 && m_mode[3]));
      if (wr_en && wr_addr == 0) m_mode = wr_data;
      if (wr_en && wr_addr >= 1 && wr_addr <= 4) m_word[8*(wr_addr-1) +: 8] = wr_data;
      m_sys_hist = {m_sys_hist[1:0], sys_sync_n};
      m_acc_hist = {m_acc_hist[1:0], acc_sync_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit so, ai, fl, ds, bad;
      m_outputs(so, ai, fl, ds);
      bad = 0;
      vectors++;
      if (sync_out !== so) begin bad = 1; $display("FAIL R8 sync_out=%0b exp=%0b t=%0t", sync_out, so, $time); end
      if (acc_init !== ai) begin bad = 1; $display("FAIL R2 acc_init=%0b exp=%0b t=%0t", acc_init, ai, $time); end
      if (freq_load !== fl) begin bad = 1; $display("FAIL R5 freq_load=%0b exp=%0b t=%0t", freq_load, fl, $time); end
      if (diag_sync !== ds) begin bad = 1; $display("FAIL R6 diag_sync=%0b exp=%0b t=%0t", diag_sync, ds, $time); end
      if (freq_q !== m_freq) begin bad = 1; $display("FAIL R4 freq_q=%h exp=%h t=%0t", freq_q, m_freq, $time); end
      if (phase_q !== m_phase) begin bad = 1; $display("FAIL R10 phase_q=%h exp=%h t=%0t", phase_q, m_phase, $time); end
      if (bad) miscompares++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sys_low(input int n);
    @(negedge clk); sys_sync_n = 0; idle(n); sys_sync_n = 1; idle(6);
  endtask

  task automatic acc_low(input int n);
    @(negedge clk); acc_sync_n = 0; idle(n); acc_sync_n = 1; idle(6);
  endtask

  initial begin
    idle(3);
    // R11: reset state seen at the ports
    vectors++;
    if ({sync_out, acc_init, freq_load, diag_sync} !== 4'b0 || freq_q !== 0 || phase_q !== 0) begin
      miscompares++;
      $display("FAIL R11 reset outputs freq=%h phase=%h exp=0", freq_q, phase_q);
    end
    rst_n = 1;
    idle(3);
    // R4: word writes with direct load off do not reach the frequency register
    wr(1, 8'h67); wr(2, 8'h45); wr(3, 8'h23); wr(4, 8'h01); idle(4);
    wr(0, 8'h08); idle(6);                  // R4 load, R10 accumulate
    wr(1, 8'hF1); idle(5);                  // R4 reload while bit 3 set
    wr(0, 8'h02);                           // R2 accumulator sync via acc strobe
    acc_low(2); acc_low(25);                // R9 held low acts once
    sys_low(2);                             // R3 sys strobe not selected here
    wr(0, 8'h06); acc_low(2); sys_low(3);   // R3 sys stands in, acc ignored
    wr(0, 8'h07); sys_low(2); acc_low(2);   // R1 gate, R3 falls back to acc
    wr(2, 8'hAA); wr(0, 8'h10); idle(3);
    acc_low(2); sys_low(2);                 // R5 synchronous load
    wr(0, 8'h20); sys_low(2); idle(10); sys_low(4);   // R6 diagnostic via ext sync
    wr(0, 8'hC0); idle(3 * TESTP + 20);     // R7 short period, R8 counter sync
    wr(0, 8'h80); idle(2 * LONGP + 20);     // R7 long period
    wr(0, 8'hA1); sys_low(2); idle(LONGP + 10);  // R8 with R1: ext ignored
    wr(0, 8'hE2); acc_low(2); idle(2 * TESTP + 10);
    wr(0, 8'h00); sys_low(2); acc_low(2); idle(5);    // R11 cleared mode
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule